// File: doc/BRIEF.md
# Capture, Compare and PWM Channel

This block is a single timer channel that gives one pin three jobs. As a capture input it watches the pin for a chosen edge and copies the value of an external free-running 16-bit timer into a pair of 8-bit data registers. The edge can also be divided down by a small event prescaler. As a compare output it watches for the moment the same timer equals the data register pair. It then sets or clears the pin, or only raises the interrupt flag, or fires a one-cycle special-event strobe. As a PWM output it runs against an external 8-bit period counter and that counter's two prescaler bits, and it produces a waveform with a 10-bit duty value.

A 4-bit mode field in the control register selects the job. The same register holds the two low bits of the PWM duty, and the low data register holds the upper eight. Both timers and the interrupt controller sit outside. The channel only reports events through a sticky flag, which software clears with a strobe.

Top module: `ccp_channel`

## Requirements
- R1: After reset the control readback, both data registers, the interrupt flag, the pin output, the pin enable and the special-event strobe are all zero.
- R2: Mode 0000 (and the unused codes 0001 to 0011) leaves the pin undriven (pin_oe low), and pin activity never sets the flag or changes the data registers.
- R3: Mode 0101 captures on each rising pin edge and mode 0100 on each falling pin edge. The clock edge that first samples the new pin level loads tmr_cnt into {data_hi, data_lo} and sets the flag. Edges of the other polarity capture nothing.
- R4: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th rising edge, counted from the last mode change.
- R5: A control write that changes the mode field clears the capture edge prescaler count.
- R6: Entering mode 1000 drives the pin low and entering 1001 drives it high. On a compare match (tmr_cnt equal to {data_hi, data_lo}), 1000 sets the pin and 1001 clears it, and either mode sets the flag.
- R7: Mode 1010 drives the pin low and keeps it low on a match, while the match still sets the flag.
- R8: In mode 1011 a match sets the flag and raises special_evt for exactly one cycle, the one after the matching clock edge.
- R9: A match counts as one event only on its first cycle. Holding tmr_cnt at the match value does not set the flag again after it has been cleared.
- R10: In PWM modes (11xx) the period ends on the clock edge where per_cnt equals per_limit and per_sub is 3. At that edge the 10-bit duty {data_lo, ctl[5:4]} is taken up, and the pin goes high if the new duty is non-zero and low if it is zero.
- R11: Within a period the PWM pin goes low on the clock edge where {per_cnt, per_sub} equals the taken-up duty. A duty beyond the period end keeps the pin high for the whole period.
- R12: A duty written in the middle of a period does not change the waveform until the next period end.
- R13: flag_clr clears the flag, but an event in the same cycle wins and the flag stays set.
- R14: The control readback ctl_q holds the mode in bits 3:0 and the duty low bits in bits 5:4, and bits 7:6 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_ctl | input | 1 | Write strobe for the control register |
| wr_lo | input | 1 | Write strobe for the low data register |
| wr_hi | input | 1 | Write strobe for the high data register |
| wdata | input | 8 | Write data |
| flag_clr | input | 1 | Clears the interrupt flag |
| tmr_cnt | input | 16 | Free-running 16-bit timer value |
| per_cnt | input | 8 | Period timer value |
| per_sub | input | 2 | Period timer prescaler bits |
| per_limit | input | 8 | Period register |
| pin_in | input | 1 | Pin level, used in capture modes |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin drive enable (compare and PWM modes) |
| ctl_q | output | 8 | Control register readback |
| data_lo | output | 8 | Low data register |
| data_hi | output | 8 | High data register |
| irq_flag | output | 1 | Sticky event flag |
| special_evt | output | 1 | One-cycle special-event strobe |

## Verification
All results are registered and due on the first clock edge after the stimulus. A capture shows in the data registers and the flag once the edge that samples the new pin level has passed, and so does a compare match on the pin and the flag. The special strobe is high only in the cycle that follows that edge. A PWM pin change follows the edge at which the period count reaches the period end or the duty. The bench drives inputs on the falling clock edge and samples half a cycle after each rising edge. Its PWM model evaluates the count that was present at that rising edge, with a closed-form rule: high at the period end when the new duty is non-zero, otherwise high exactly while the count is below the active duty.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

    typedef enum logic [1:0] {
        GRP_OFF = 2'b00,
        GRP_CAP = 2'b01,
        GRP_CMP = 2'b10,
        GRP_PWM = 2'b11
    } grp_e;

    typedef enum logic [1:0] {
        ACT_SET     = 2'b00,
        ACT_CLR     = 2'b01,
        ACT_IRQ     = 2'b10,
        ACT_SPECIAL = 2'b11
    } cmp_act_e;

    typedef struct packed {
        grp_e       grp;
        logic       falling;
        logic [1:0] div_sel;
        cmp_act_e   act;
    } mode_dec_t;

    function automatic mode_dec_t decode_mode(input logic [3:0] m);
        mode_dec_t d;
        d.grp     = grp_e'(m[3:2]);
        d.falling = (m[1:0] == 2'b00);
        d.div_sel = m[1:0];
        d.act     = cmp_act_e'(m[1:0]);
        return d;
    endfunction

    // number of qualifying edges per capture
    function automatic int unsigned cap_div(input logic [1:0] sel);
        case (sel)
            2'b10:   return 4;
            2'b11:   return 16;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/ccp_capture.sv
module ccp_capture
    import ccp_pkg::*;
#(
    parameter int PSW = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       falling,
    input  logic [1:0] div_sel,
    input  logic       clr,
    input  logic       pin,
    output logic       evt
);
    logic           pin_q;
    logic [PSW-1:0] cnt;
    logic [PSW-1:0] limit;
    logic           edge_seen;

    assign limit     = PSW'(cap_div(div_sel) - 1);
    assign edge_seen = falling ? (~pin & pin_q) : (pin & ~pin_q);
    assign evt       = en & ~clr & edge_seen & (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b0;
            cnt   <= '0;
        end else begin
            pin_q <= pin;
            if (!en || clr) begin
                cnt <= '0;
            end else if (edge_seen) begin
                cnt <= (cnt == limit) ? '0 : cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ccp_compare.sv
module ccp_compare #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [TW-1:0] tmr,
    input  logic [TW-1:0] ref_val,
    output logic          hit
);
    logic match;
    logic match_q;

    assign match = en & (tmr == ref_val);
    assign hit   = match & ~match_q;

    always_ff @(posedge clk) begin
        if (rst) match_q <= 1'b0;
        else     match_q <= match;
    end
endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm #(
    parameter int PW = 8,
    parameter int SW = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PW-1:0]    cnt,
    input  logic [SW-1:0]    sub,
    input  logic [PW-1:0]    limit,
    input  logic [PW+SW-1:0] duty_buf,
    output logic             out,
    output logic             period_end
);
    localparam int DTW = PW + SW;

    logic [DTW-1:0] duty_act;
    logic [DTW-1:0] pos;

    assign pos        = {cnt, sub};
    assign period_end = (cnt == limit) & (&sub);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            duty_act <= '0;
            out      <= 1'b0;
        end else if (period_end) begin
            duty_act <= duty_buf;
            out      <= (duty_buf != '0);
        end else if (pos == duty_act) begin
            out      <= 1'b0;
        end
    end
endmodule

// File: rtl/ccp_channel.sv
module ccp_channel
    import ccp_pkg::*;
#(
    parameter int DW  = 8,
    parameter int SW  = 2,
    parameter int PSW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctl,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [DW-1:0] wdata,
    input  logic          flag_clr,
    input  logic [2*DW-1:0] tmr_cnt,
    input  logic [DW-1:0] per_cnt,
    input  logic [SW-1:0] per_sub,
    input  logic [DW-1:0] per_limit,
    input  logic          pin_in,
    output logic          pin_out,
    output logic          pin_oe,
    output logic [DW-1:0] ctl_q,
    output logic [DW-1:0] data_lo,
    output logic [DW-1:0] data_hi,
    output logic          irq_flag,
    output logic          special_evt
);
    localparam int TW  = 2 * DW;
    localparam int DTW = DW + SW;

    logic [3:0]    mode;
    logic [SW-1:0] duty_lsb;
    mode_dec_t     dec;
    mode_dec_t     new_dec;
    logic          mode_change;
    logic          cap_evt;
    logic          cmp_hit;
    logic          cmp_out;
    logic          pwm_out;
    logic          pwm_end;
    logic [DTW-1:0] duty_buf;

    assign dec         = decode_mode(mode);
    assign new_dec     = decode_mode(wdata[3:0]);
    assign mode_change = wr_ctl & (wdata[3:0] != mode);
    assign duty_buf    = {data_lo, duty_lsb};
    assign ctl_q       = DW'({duty_lsb, mode});

    ccp_capture #(.PSW(PSW)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .en      (dec.grp == GRP_CAP),
        .falling (dec.falling),
        .div_sel (dec.div_sel),
        .clr     (mode_change),
        .pin     (pin_in),
        .evt     (cap_evt)
    );

    ccp_compare #(.TW(TW)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .en      (dec.grp == GRP_CMP),
        .tmr     (tmr_cnt),
        .ref_val ({data_hi, data_lo}),
        .hit     (cmp_hit)
    );

    ccp_pwm #(.PW(DW), .SW(SW)) u_pwm (
        .clk        (clk),
        .rst        (rst),
        .en         (dec.grp == GRP_PWM),
        .cnt        (per_cnt),
        .sub        (per_sub),
        .limit      (per_limit),
        .duty_buf   (duty_buf),
        .out        (pwm_out),
        .period_end (pwm_end)
    );

    // control register
    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= '0;
            duty_lsb <= '0;
        end else if (wr_ctl) begin
            mode     <= wdata[3:0];
            duty_lsb <= wdata[4 +: SW];
        end
    end

    // data register pair: a capture takes priority over a write
    always_ff @(posedge clk) begin
        if (rst) begin
            data_lo <= '0;
            data_hi <= '0;
        end else if (cap_evt) begin
            {data_hi, data_lo} <= tmr_cnt;
        end else begin
            if (wr_lo) data_lo <= wdata;
            if (wr_hi) data_hi <= wdata;
        end
    end

    // compare pin state
    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_out <= 1'b0;
        end else if (wr_ctl) begin
            cmp_out <= (new_dec.grp == GRP_CMP) && (new_dec.act == ACT_CLR);
        end else if (cmp_hit) begin
            case (dec.act)
                ACT_SET: cmp_out <= 1'b1;
                ACT_CLR: cmp_out <= 1'b0;
                default: cmp_out <= cmp_out;
            endcase
        end
    end

    // flag and special strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_flag    <= 1'b0;
            special_evt <= 1'b0;
        end else begin
            if (cap_evt || cmp_hit) irq_flag <= 1'b1;
            else if (flag_clr)      irq_flag <= 1'b0;
            special_evt <= cmp_hit && (dec.act == ACT_SPECIAL);
        end
    end

    always_comb begin
        case (dec.grp)
            GRP_CMP: begin pin_oe = 1'b1; pin_out = cmp_out; end
            GRP_PWM: begin pin_oe = 1'b1; pin_out = pwm_out; end
            default: begin pin_oe = 1'b0; pin_out = 1'b0;    end
        endcase
    end

    logic unused_end;
    assign unused_end = pwm_end;
endmodule

// File: rtl/ccp_channel_chk.sv
module ccp_channel_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_ctl,
    input logic [DW-1:0] ctl_q,
    input logic          irq_flag,
    input logic          special_evt
);
    // R8: strobe only after a cycle spent in the special-event mode
    p_special_mode_r8: assert property (@(posedge clk) disable iff (rst)
        special_evt |-> $past(ctl_q[3:0] == 4'b1011));

    // R8: strobe lasts one cycle
    p_special_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        special_evt |=> !special_evt);

    // R2: the flag can only rise out of a capture or compare mode
    p_flag_source_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag) |-> $past(ctl_q[3:2] == 2'b01 || ctl_q[3:2] == 2'b10));

    // R14: control contents change only through a write
    p_ctl_hold_r14: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_ctl) |-> $stable(ctl_q));

    // R14: upper control bits read as zero
    p_ctl_top_zero_r14: assert property (@(posedge clk) disable iff (rst)
        $past(wr_ctl) |-> (ctl_q[7:6] == 2'b00));
endmodule

bind ccp_channel ccp_channel_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_ctl      (wr_ctl),
    .ctl_q       (ctl_q),
    .irq_flag    (irq_flag),
    .special_evt (special_evt)
);

// File: tb/test_ccp_channel.sv
module test_ccp_channel;
    localparam int PRD  = 4;
    localparam int PEND = 4 * PRD + 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_ctl = 0, wr_lo = 0, wr_hi = 0, flag_clr = 0, pin_in = 0;
    logic [7:0]  wdata = '0;
    logic [15:0] tmr_cnt = '0;
    logic [7:0]  per_cnt = '0;
    logic [1:0]  per_sub = '0;
    logic [7:0]  per_limit = 8'(PRD);
    logic        pin_out, pin_oe, irq_flag, special_evt;
    logic [7:0]  ctl_q, data_lo, data_hi;

    int checks = 0, errors = 0;
    bit done = 0;
    int c = 0, last_c = 0;
    bit pwm_on = 0;
    int dbuf = 0, dact = 0, blo = 0, bl = 0;
    bit exp_pwm = 0;

    always #4 clk = ~clk;

    ccp_channel i_ccp_channel (
        .clk(clk), .rst(rst), .wr_ctl(wr_ctl), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wdata(wdata), .flag_clr(flag_clr), .tmr_cnt(tmr_cnt),
        .per_cnt(per_cnt), .per_sub(per_sub), .per_limit(per_limit),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .ctl_q(ctl_q),
        .data_lo(data_lo), .data_hi(data_hi), .irq_flag(irq_flag),
        .special_evt(special_evt)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        int cc;
        cc = c;
        @(posedge clk);
        last_c = cc;
        if (pwm_on) begin
            if (cc == PEND) begin
                dact    = dbuf;
                exp_pwm = (dbuf != 0);
            end else begin
                exp_pwm = (cc < dact);
            end
        end else begin
            dact    = 0;
            exp_pwm = 0;
        end
        c = (cc == PEND) ? 0 : cc + 1;
        @(negedge clk);
        per_cnt = 8'(c >> 2);
        per_sub = 2'(c);
    endtask

    task automatic wreg(input int kind, input logic [7:0] v);
        wdata = v;
        if (kind == 0) wr_ctl = 1;
        else if (kind == 1) wr_lo = 1;
        else wr_hi = 1;
        step();
        wr_ctl = 0; wr_lo = 0; wr_hi = 0;
        if (kind == 0) begin
            bl     = int'(v[5:4]);
            pwm_on = (v[3:2] == 2'b11);
        end else if (kind == 1) begin
            blo = int'(v);
        end
        dbuf = blo * 4 + bl;
    endtask

    task automatic clear_flag();
        flag_clr = 1; step(); flag_clr = 0;
    endtask

    int exp_data;

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) step();
        rst = 0;
        // R1 reset state
        check("R1 ctl", ctl_q, 0);
        check("R1 data", {data_hi, data_lo}, 0);
        check("R1 flag", irq_flag, 0);
        check("R1 pin", {pin_oe, pin_out, special_evt}, 0);

        // R14 readback
        wreg(0, 8'hFF);
        check("R14 ctl readback", ctl_q, 8'h3F);
        wreg(0, 8'h00);
        check("R2 off pin_oe", pin_oe, 0);

        // R2 off mode ignores the pin
        exp_data = {data_hi, data_lo};
        for (int k = 0; k < 6; k++) begin
            tmr_cnt = 16'(16'h0A00 + k);
            pin_in = ~pin_in;
            step();
            check("R2 flag", irq_flag, 0);
            check("R2 data", {data_hi, data_lo}, exp_data);
            check("R2 oe", pin_oe, 0);
        end
        pin_in = 0; step();

        // R3 rising capture
        wreg(0, 8'h05);
        for (int k = 0; k < 6; k++) begin
            tmr_cnt = 16'(16'h1000 + k * 16'h0111);
            pin_in = 1;
            step();
            check("R3 rise data", {data_hi, data_lo}, 16'h1000 + k * 16'h0111);
            check("R3 rise flag", irq_flag, 1);
            exp_data = 16'h1000 + k * 16'h0111;
            flag_clr = 1; tmr_cnt = 16'hFFFF; pin_in = 0;
            step();
            flag_clr = 0;
            check("R3 rise ignores fall", {data_hi, data_lo}, exp_data);
            check("R3 no flag on fall", irq_flag, 0);
        end
        // R3 falling capture
        wreg(0, 8'h04);
        for (int k = 0; k < 6; k++) begin
            tmr_cnt = 16'(16'h3000 + k);
            pin_in = 1;
            step();
            check("R3 fall ignores rise", {data_hi, data_lo}, exp_data);
            tmr_cnt = 16'(16'h5000 + k * 3);
            pin_in = 0;
            step();
            exp_data = 16'h5000 + k * 3;
            check("R3 fall data", {data_hi, data_lo}, exp_data);
        end

        // R4 prescaled captures
        for (int s = 6; s <= 7; s++) begin
            int div;
            div = (s == 6) ? 4 : 16;
            wreg(0, 8'(s));
            clear_flag();
            for (int k = 1; k <= 2 * div + 3; k++) begin
                tmr_cnt = 16'(16'h2000 + k + s * 256);
                pin_in = 1;
                step();
                if (k % div == 0) exp_data = 16'h2000 + k + s * 256;
                check("R4 data", {data_hi, data_lo}, exp_data);
                check("R4 flag", irq_flag, (k >= div) ? 1 : 0);
                pin_in = 0;
                step();
            end
        end

        // R5 mode change clears the prescaler
        wreg(0, 8'h06);
        clear_flag();
        for (int k = 0; k < 2; k++) begin
            tmr_cnt = 16'(16'h7700 + k); pin_in = 1; step(); pin_in = 0; step();
        end
        wreg(0, 8'h07);
        wreg(0, 8'h06);
        for (int k = 1; k <= 4; k++) begin
            tmr_cnt = 16'(16'h7800 + k);
            pin_in = 1;
            step();
            if (k == 4) exp_data = 16'h7804;
            check("R5 data", {data_hi, data_lo}, exp_data);
            check("R5 flag", irq_flag, (k == 4) ? 1 : 0);
            pin_in = 0;
            step();
        end

        // R6 compare set / clear
        wreg(0, 8'h00);
        wreg(1, 8'h00);
        wreg(2, 8'h01);
        for (int m = 8; m <= 9; m++) begin
            tmr_cnt = 16'h00F0;
            wreg(0, 8'(m));
            clear_flag();
            check("R6 entry oe", pin_oe, 1);
            check("R6 entry level", pin_out, (m == 9) ? 1 : 0);
            for (int t = 16'h00F0; t <= 16'h0110; t++) begin
                tmr_cnt = 16'(t);
                step();
                check("R6 pin", pin_out, (m == 8) ? (t >= 16'h100) : (t < 16'h100));
                check("R6 flag", irq_flag, (t >= 16'h100) ? 1 : 0);
            end
        end

        // R7 software-only compare
        tmr_cnt = 16'h00FF;
        wreg(0, 8'h0A);
        clear_flag();
        check("R7 entry level", pin_out, 0);
        tmr_cnt = 16'h0100;
        step();
        check("R7 flag", irq_flag, 1);
        check("R7 pin stays", {pin_oe, pin_out}, 2'b10);
        // R9 held match is one event
        clear_flag();
        step(); step();
        check("R9 held match", irq_flag, 0);
        // R13 set wins over clear
        tmr_cnt = 16'h00FF; step();
        tmr_cnt = 16'h0100; flag_clr = 1; step(); flag_clr = 0;
        check("R13 set wins", irq_flag, 1);
        clear_flag();
        check("R13 clear", irq_flag, 0);

        // R8 special event
        tmr_cnt = 16'h00FF;
        wreg(0, 8'h0B);
        clear_flag();
        check("R8 idle", special_evt, 0);
        tmr_cnt = 16'h0100; step();
        check("R8 pulse", special_evt, 1);
        check("R8 flag", irq_flag, 1);
        step();
        check("R8 pulse end", special_evt, 0);
        step();
        check("R8 quiet", special_evt, 0);

        // R10 R11 R12 PWM sweep over duty values
        wreg(0, 8'h00);
        for (int d = 0; d <= 22; d++) begin
            wreg(1, 8'(d >> 2));
            wreg(0, {2'b00, 2'(d), 4'b1100});
            for (int n = 0; n < 47; n++) begin
                string tag;
                step();
                if (last_c == PEND) tag = "R10 period end";
                else if (dact != dbuf) tag = "R12 buffered duty";
                else tag = "R11 duty";
                check(tag, pin_out, exp_pwm);
                check("R10 oe", pin_oe, 1);
            end
        end
        wreg(0, 8'h00);
        check("R2 off after pwm", {pin_oe, pin_out}, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule